// File: doc/BRIEF.md
# SMT Commit Thread Selector

In a multithreaded out-of-order core, only one hardware thread can use a given commit slot. This block decides which thread that is. For every thread it receives a state code, a flag for an empty reorder buffer, a flag that says the buffer head is ready, and the sequence number of that head. It returns a thread index and a valid bit. A two-bit policy input chooses how the winner is picked: a rotating round-robin list, the oldest ready head, or an aggressive mode that uses the oldest-head rule.

The selection logic is purely combinational, so the retire logic can ask for a winner several times in one cycle as the reorder buffer heads change. The only state in the block is the round-robin order. That order changes at a clock edge, and only when the retire logic asserts `take_i` while a round-robin grant is valid. When the block is built for one thread, it skips the buffer checks and grants that thread whenever its state allows it.

Top module: `smt_commit_sel`

## Requirements
- R1: The thread state codes are 0 idle, 1 running, 2 buffer squashing, 3 trap pending and 4 fetch trap pending. Only codes 0, 1 and 4 are eligible, and a thread with any other code is never granted.
- R2: With more than one thread, a thread qualifies only when it is eligible, its buffer is not empty (`rob_empty_i` low) and its head is ready (`head_rdy_i` high).
- R3: After reset, the round-robin order is ascending thread index, so thread 0 wins when every thread qualifies.
- R4: In round-robin mode (policy 1), the grant goes to the first qualifying thread in the current order.
- R5: On a clock edge where `take_i` is high, the policy is round-robin and the grant is valid, the granted thread moves to the tail of the order. The other threads keep their relative order.
- R6: The order does not change when `take_i` is low, when the policy is not round-robin, or when no thread qualifies.
- R7: In oldest-ready mode (policy 2 or 3), the grant goes to the qualifying thread with the smallest head sequence number, compared as unsigned values.
- R8: When two qualifying heads in oldest-ready or aggressive mode have the same sequence number, the lower thread index wins.
- R9: Aggressive mode (policy 0) gives the same selection as oldest-ready mode, and `take_i` has no effect on its result.
- R10: When no thread qualifies, `sel_valid_o` is low and `sel_tid_o` is 0.
- R11: With a single thread, `sel_valid_o` follows the eligibility of that thread's state alone, whatever the empty and ready flags say, and `sel_tid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | 0 aggressive, 1 round-robin, 2 or 3 oldest-ready |
| status_i | input | 3*NUM_THR | State code per thread; thread i in bits [3i+2:3i] |
| rob_empty_i | input | NUM_THR | Reorder buffer empty, per thread |
| head_rdy_i | input | NUM_THR | Buffer head ready to retire, per thread |
| head_seq_i | input | SEQ_W*NUM_THR | Head sequence number per thread; thread i in bits [SEQ_W*i +: SEQ_W] |
| take_i | input | 1 | Current grant is consumed; advances the round-robin order |
| sel_valid_o | output | 1 | A thread has been selected |
| sel_tid_o | output | TID_W | Index of the selected thread |

## Verification
The only hidden state is the round-robin order. If it is wrong, for example a lost rotation, a rotation that should not happen, or a reordering of the threads that were not granted, the effect shows on `sel_tid_o` at the first round-robin query after the faulty edge where several threads qualify. The bench therefore follows every consumed grant with a query in which all threads qualify, and with queries that make the scan skip threads. Errors in the eligibility decode or in the sequence comparison show up in the same cycle as the inputs that expose them. To catch them, the bench sets each state code, uses empty buffers with ready flags, and uses tied sequence numbers.

// File: rtl/smt_sel_pkg.sv
package smt_sel_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    TS_IDLE    = 3'd0,
    TS_RUN     = 3'd1,
    TS_ROB_SQ  = 3'd2,
    TS_TRAP    = 3'd3,
    TS_FTRAP   = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_AGGR   = 2'd0,
    POL_RR     = 2'd1,
    POL_OLD    = 2'd2,
    POL_OLD_B  = 2'd3
  } pol_e;

  function automatic logic st_eligible(logic [ST_W-1:0] s);
    return (s == TS_IDLE) || (s == TS_RUN) || (s == TS_FTRAP);
  endfunction
endpackage

// File: rtl/smt_qualify.sv
module smt_qualify
  import smt_sel_pkg::*;
#(
  parameter int NUM_THR = 4
) (
  input  logic [ST_W*NUM_THR-1:0] status_i,
  input  logic [NUM_THR-1:0]      rob_empty_i,
  input  logic [NUM_THR-1:0]      head_rdy_i,
  output logic [NUM_THR-1:0]      elig_o,
  output logic [NUM_THR-1:0]      qual_o
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign elig_o[t] = st_eligible(status_i[t*ST_W +: ST_W]);
    assign qual_o[t] = elig_o[t] & ~rob_empty_i[t] & head_rdy_i[t];
  end
endmodule

// File: rtl/smt_rr_order.sv
module smt_rr_order #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] qual_i,
  input  logic               upd_i,
  output logic               valid_o,
  output logic [TID_W-1:0]   tid_o
);
  logic [TID_W-1:0] ord_q [NUM_THR];
  logic [TID_W-1:0] ord_d [NUM_THR];
  logic [TID_W-1:0] hit_pos;
  logic             hit;

  // first qualifying slot in list order
  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    for (int p = 0; p < NUM_THR; p++) begin
      if (!hit && qual_i[ord_q[p]]) begin
        hit     = 1'b1;
        hit_pos = TID_W'(p);
      end
    end
  end

  assign valid_o = hit;
  assign tid_o   = hit ? ord_q[hit_pos] : '0;

  // granted entry goes to the tail, later entries shift up
  always_comb begin
    for (int i = 0; i < NUM_THR - 1; i++) begin
      ord_d[i] = (i < int'(hit_pos)) ? ord_q[i] : ord_q[i+1];
    end
    ord_d[NUM_THR-1] = ord_q[hit_pos];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_THR; i++) ord_q[i] <= TID_W'(i);
    end else if (upd_i && hit) begin
      for (int i = 0; i < NUM_THR; i++) ord_q[i] <= ord_d[i];
    end
  end
endmodule

// File: rtl/smt_oldest_pick.sv
module smt_oldest_pick #(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  parameter int TID_W   = 2
) (
  input  logic [NUM_THR-1:0]       qual_i,
  input  logic [SEQ_W*NUM_THR-1:0] seq_i,
  output logic                     valid_o,
  output logic [TID_W-1:0]         tid_o
);
  logic [SEQ_W-1:0] best;

  // strict less keeps the lower index on ties
  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    best    = '0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (qual_i[t] && (!valid_o || seq_i[t*SEQ_W +: SEQ_W] < best)) begin
        valid_o = 1'b1;
        tid_o   = TID_W'(t);
        best    = seq_i[t*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/smt_commit_sel.sv
module smt_commit_sel
  import smt_sel_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               policy_i,
  input  logic [ST_W*NUM_THR-1:0]  status_i,
  input  logic [NUM_THR-1:0]       rob_empty_i,
  input  logic [NUM_THR-1:0]       head_rdy_i,
  input  logic [SEQ_W*NUM_THR-1:0] head_seq_i,
  input  logic                     take_i,
  output logic                     sel_valid_o,
  output logic [TID_W-1:0]         sel_tid_o
);
  logic [NUM_THR-1:0] elig, qual;

  smt_qualify #(.NUM_THR(NUM_THR)) i_qual (
    .status_i   (status_i),
    .rob_empty_i(rob_empty_i),
    .head_rdy_i (head_rdy_i),
    .elig_o     (elig),
    .qual_o     (qual)
  );

  if (NUM_THR == 1) begin : g_single
    assign sel_valid_o = elig[0];
    assign sel_tid_o   = '0;
  end else begin : g_multi
    logic             rr_v, old_v, is_rr;
    logic [TID_W-1:0] rr_t, old_t;

    assign is_rr = (pol_e'(policy_i) == POL_RR);

    smt_rr_order #(.NUM_THR(NUM_THR), .TID_W(TID_W)) i_rr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .qual_i (qual),
      .upd_i  (take_i & is_rr),
      .valid_o(rr_v),
      .tid_o  (rr_t)
    );

    smt_oldest_pick #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W), .TID_W(TID_W)) i_old (
      .qual_i (qual),
      .seq_i  (head_seq_i),
      .valid_o(old_v),
      .tid_o  (old_t)
    );

    assign sel_valid_o = is_rr ? rr_v : old_v;
    assign sel_tid_o   = is_rr ? rr_t : old_t;
  end
endmodule

// File: rtl/smt_commit_sel_chk.sv
module smt_commit_sel_chk #(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [1:0]               policy_i,
  input logic [3*NUM_THR-1:0]     status_i,
  input logic [NUM_THR-1:0]       rob_empty_i,
  input logic [NUM_THR-1:0]       head_rdy_i,
  input logic [SEQ_W*NUM_THR-1:0] head_seq_i,
  input logic                     take_i,
  input logic                     sel_valid_o,
  input logic [TID_W-1:0]         sel_tid_o
);
  logic [NUM_THR-1:0] ok_st, q;
  logic any_q, sel_q, older, tie_lo;
  logic [SEQ_W-1:0] sel_seq;

  always_comb begin
    sel_q   = 1'b0;
    sel_seq = '0;
    for (int t = 0; t < NUM_THR; t++) begin
      ok_st[t] = status_i[3*t +: 3] inside {3'd0, 3'd1, 3'd4};
      q[t]     = ok_st[t] && !rob_empty_i[t] && head_rdy_i[t];
      if (sel_tid_o == TID_W'(t)) begin
        sel_q   = q[t];
        sel_seq = head_seq_i[t*SEQ_W +: SEQ_W];
      end
    end
    any_q  = |q;
    older  = 1'b0;
    tie_lo = 1'b0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (q[t] && head_seq_i[t*SEQ_W +: SEQ_W] < sel_seq) older = 1'b1;
      if (q[t] && head_seq_i[t*SEQ_W +: SEQ_W] == sel_seq && TID_W'(t) < sel_tid_o)
        tie_lo = 1'b1;
    end
  end

  if (NUM_THR > 1) begin : g_multi
    assert_grant_qualifies_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o |-> sel_q);
    assert_none_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_q |-> (!sel_valid_o && sel_tid_o == '0));
    assert_oldest_min_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i != 2'd1 && sel_valid_o) |-> !older);
    assert_tie_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i != 2'd1 && sel_valid_o) |-> !tie_lo);
    assert_rr_rotates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i == 2'd1 && take_i && sel_valid_o) |=>
        (!(policy_i == 2'd1 && &q) || sel_tid_o != $past(sel_tid_o)));
    assert_rr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i == 2'd1 && !take_i) |=>
        (!(policy_i == 2'd1 && $stable(q)) || $stable(sel_tid_o)));
  end else begin : g_single
    assert_single_elig_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o == ok_st[0]);
  end
endmodule

bind smt_commit_sel smt_commit_sel_chk #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W)) i_chk (.*);

// File: tb/test_smt_commit_sel.sv
module test_smt_commit_sel;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int SW    = 16;

  logic clk = 1'b0, rst_n = 1'b0, take = 1'b0;
  logic [1:0] pol = 2'd1;
  logic [2:0] st [N];
  logic [N-1:0] emp, rdy;
  logic [SW-1:0] seq [N];
  logic [3*N-1:0] st_bus;
  logic [SW*N-1:0] seq_bus;
  logic vld;
  logic [1:0] tid;

  logic [2:0] s1_st = 3'd0;
  logic s1_emp = 1'b1, s1_rdy = 1'b0;
  logic s1_vld;
  logic [0:0] s1_tid;

  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      st_bus[3*i +: 3]   = st[i];
      seq_bus[SW*i +: SW] = seq[i];
    end
  end

  smt_commit_sel #(.NUM_THR(N), .SEQ_W(SW)) i_smt_commit_sel (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .status_i(st_bus),
    .rob_empty_i(emp), .head_rdy_i(rdy), .head_seq_i(seq_bus),
    .take_i(take), .sel_valid_o(vld), .sel_tid_o(tid)
  );

  smt_commit_sel #(.NUM_THR(1), .SEQ_W(SW)) i_single (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .status_i(s1_st),
    .rob_empty_i(s1_emp), .head_rdy_i(s1_rdy), .head_seq_i(16'd7),
    .take_i(take), .sel_valid_o(s1_vld), .sel_tid_o(s1_tid)
  );

  task automatic chk(string req, logic av, int at, logic ev, int et);
    total++;
    if (av !== ev || at != et) begin
      bad++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               req, av, at, ev, et);
    end
  endtask

  task automatic all_ready();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      st[i] = 3'd1; seq[i] = SW'(100 + i);
    end
    emp = '0; rdy = '1;
    #1;
  endtask

  task automatic pulse_take();
    @(negedge clk); take = 1'b1;
    @(negedge clk); take = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) begin st[i] = 3'd0; seq[i] = '0; end
    emp = '1; rdy = '0;
    do_reset();
    chk("R10 reset idle", vld, int'(tid), 1'b0, 0);
    all_ready();
    chk("R3 initial order", vld, int'(tid), 1'b1, 0);
  endtask

  task automatic t_elig();
    @(negedge clk); pol = 2'd2; #1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      st[0] = 3'(c); #1;
      chk("R1 state code", vld, int'(tid), 1'b1,
          (c == 0 || c == 1 || c == 4) ? 0 : 1);
    end
    @(negedge clk); st[0] = 3'd1; emp[0] = 1'b1; #1;
    chk("R2 empty skipped", vld, int'(tid), 1'b1, 1);
    @(negedge clk); emp[0] = 1'b0; rdy[0] = 1'b0; #1;
    chk("R2 not ready skipped", vld, int'(tid), 1'b1, 1);
    @(negedge clk); rdy = '0; #1;
    chk("R10 nothing ready", vld, int'(tid), 1'b0, 0);
  endtask

  task automatic t_rr();
    do_reset();
    all_ready();
    @(negedge clk); pol = 2'd1; #1;
    for (int k = 0; k < 5; k++) begin
      chk("R5 rotation", vld, int'(tid), 1'b1, k % N);
      pulse_take();
    end
    // order now 1,2,3,0
    @(negedge clk); rdy[1] = 1'b0; #1;
    chk("R4 skip unready", vld, int'(tid), 1'b1, 2);
    pulse_take();                        // order 1,3,0,2
    @(negedge clk); rdy = '1; #1;
    chk("R5 others keep order", vld, int'(tid), 1'b1, 1);
    pulse_take();                        // order 3,0,2,1
    chk("R5 tail move", vld, int'(tid), 1'b1, 3);
  endtask

  task automatic t_rr_hold();
    repeat (3) @(negedge clk);
    #1;
    chk("R6 hold without take", vld, int'(tid), 1'b1, 3);
    @(negedge clk); pol = 2'd2; #1;
    pulse_take();
    @(negedge clk); pol = 2'd1; #1;
    chk("R6 take in other policy", vld, int'(tid), 1'b1, 3);
    @(negedge clk); rdy = '0; #1;
    pulse_take();
    @(negedge clk); rdy = '1; #1;
    chk("R6 take with no grant", vld, int'(tid), 1'b1, 3);
    do_reset();
    chk("R3 reset restores order", vld, int'(tid), 1'b1, 0);
  endtask

  task automatic t_oldest();
    all_ready();
    @(negedge clk); pol = 2'd2;
    seq[0] = 16'd40; seq[1] = 16'd10; seq[2] = 16'd30; seq[3] = 16'd20; #1;
    chk("R7 smallest seq", vld, int'(tid), 1'b1, 1);
    @(negedge clk); st[1] = 3'd3; #1;
    chk("R7 trap thread excluded", vld, int'(tid), 1'b1, 3);
    @(negedge clk); pol = 2'd3; #1;
    chk("R7 policy code 3", vld, int'(tid), 1'b1, 3);
    @(negedge clk); pol = 2'd2; st[1] = 3'd1;
    seq[0] = 16'd5; seq[1] = 16'd9; seq[2] = 16'd5; seq[3] = 16'd7; #1;
    chk("R8 tie to lower index", vld, int'(tid), 1'b1, 0);
    @(negedge clk); emp[0] = 1'b1; #1;
    chk("R8 tie after skip", vld, int'(tid), 1'b1, 2);
  endtask

  task automatic t_aggr();
    @(negedge clk); pol = 2'd0; #1;
    chk("R9 aggressive matches oldest", vld, int'(tid), 1'b1, 2);
    pulse_take();
    chk("R9 take ignored", vld, int'(tid), 1'b1, 2);
    @(negedge clk); emp[0] = 1'b0; seq[3] = 16'd1; #1;
    chk("R9 re-query same cycle inputs", vld, int'(tid), 1'b1, 3);
  endtask

  task automatic t_single();
    @(negedge clk); s1_st = 3'd1; s1_emp = 1'b1; s1_rdy = 1'b0; #1;
    chk("R11 single running", s1_vld, int'(s1_tid), 1'b1, 0);
    @(negedge clk); s1_st = 3'd2; s1_emp = 1'b0; s1_rdy = 1'b1; #1;
    chk("R11 single squashing", s1_vld, int'(s1_tid), 1'b0, 0);
    @(negedge clk); s1_st = 3'd4; #1;
    chk("R11 single fetch trap", s1_vld, int'(s1_tid), 1'b1, 0);
  endtask

  initial begin
    t_reset();
    t_elig();
    t_rr();
    t_rr_hold();
    t_oldest();
    t_aggr();
    t_single();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    total++; bad++;
    $display("FAIL watchdog: got running, expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule